// File: doc/BRIEF.md
# Serial Command Port with Key Readout

This block is the slave end of a four-wire serial link from a host controller: a select line, a serial clock, a data input and an open-drain data output. While select is high, the host shifts in a frame. The first four bits are an address and the rest are payload, up to forty bits in all. When select drops, the frame is committed. A display address produces a one-cycle write strobe toward the display memory, carrying the row, the payload and the number of payload bits that arrived. One of the two configuration addresses updates a configuration register held inside the block.

Two further addresses request a readout of externally latched key data. After such a frame, the next select-high phase is a readout phase. The block pulls the data line low or releases it to present a key-present flag and then one group of key bits. Each serial clock edge advances one bit.

All serial inputs are oversampled in the system clock through synchronizer stages. Every output is registered. An input change therefore becomes visible at the outputs after the third rising system-clock edge that follows it.

Top module: `ser_cmd_port`

## Requirements
- R1: Data bits are taken only on a rising serial clock edge while select is high. Serial clock or data activity while select is low changes no output and does not disturb the next frame.
- R2: Bits arrive least significant first. The first four bits form the address, bit 0 first. The following bits land in payload bit 0 upward, and a display commit presents them on `disp_data` with `disp_row` equal to the address.
- R3: At most 40 bits are kept per frame. Later bits are dropped, so the payload never exceeds 36 bits and `disp_len` never exceeds 36.
- R4: Addresses 0 to 4 are display rows at all times. Addresses 5 to 7 are display rows only while `duty8` is 1. Addresses 12 to 15, and rows 5 to 7 while `duty8` is 0, produce no write and change no register.
- R5: A frame cut short after at least its address is still committed. `disp_len` equals the number of received payload bits, and payload bits that never arrived read as 0, including in configuration writes.
- R6: Address 8 loads payload bit 0 into `duty8`, bit 1 into `ext_clk` and bits 7:4 into `gp_mode`. Address 9 loads bit 0 into `all_on`, bit 1 into `all_off`, bit 2 into `run` and bits 7:4 into `gp_val`. Payload bits 3:2 of address 8 and bit 3 of address 9 are discarded.
- R7: Synchronous reset clears every configuration output, `disp_we`, `disp_row`, `disp_data`, `disp_len` and `sdo_low`.
- R8: A committed frame to address 10 or 11 arms a readout of key group 0 or 1. Group g covers `key_bits[28g+27:28g]`. On the next select rise the line shows `key_flag`, and each later serial clock rise advances to the group's keys in ascending order. A 1 is shown by releasing the line (`sdo_low`=0), and after the 29 bits the line stays released.
- R9: Select going low during a readout ends it. The line is released, nothing is committed, and the next frame is received normally.
- R10: `sdo_low` is 0 whenever no readout is in progress, including during every input frame.
- R11: A commit happens only when select falls after at least four bits. A frame with fewer bits has no effect, and `disp_we` is a single-cycle pulse.
- R12: A serial clock rise that is sampled in the same cycle as the select fall is not taken. The frame commits with the bits received before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Chip select from the host, high during a transfer |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| key_flag | input | 1 | Latched key-present flag |
| key_bits | input | KEY_BITS | Latched key states, bit i for key i |
| sdo_low | output | 1 | 1 pulls the serial output line low; 0 releases it |
| disp_we | output | 1 | One-cycle display row write strobe |
| disp_row | output | ROW_W | Display row of the write |
| disp_data | output | FRAME_BITS-4 | Display payload, first received bit in bit 0 |
| disp_len | output | clog2(FRAME_BITS-3) | Number of payload bits received |
| duty8 | output | 1 | Eight-common mode selected |
| ext_clk | output | 1 | External clock source selected |
| gp_mode | output | 4 | Per-pin segment (0) or general-purpose (1) mode |
| all_on | output | 1 | Force all segments on |
| all_off | output | 1 | Force all segments off |
| run | output | 1 | Display and key scanning enabled |
| gp_val | output | 4 | General-purpose output levels |

## Verification
Bit capture and frame commit can fall in the same cycle. This happens when the host drops select at the same instant as it raises the serial clock for a last bit. The bench provokes it by switching both inputs on the same clock edge at the end of a display frame. A behavioural reference model, fed the same synchronized view, expects the frame to commit with that final bit missing and `disp_len` one lower. Readout start and frame reception also share the select-rise event, and arming followed by an early select drop checks that the two never mix.

// File: rtl/ser_cmd_pkg.sv
package ser_cmd_pkg;
  localparam int ADDR_W = 4;
  localparam int CFG_W = 8;
  localparam logic [ADDR_W-1:0] ADR_CFG_A = 4'd8;
  localparam logic [ADDR_W-1:0] ADR_CFG_B = 4'd9;
  localparam logic [ADDR_W-1:0] ADR_KEY_LO = 4'd10;
  localparam int ROWS_NARROW = 5;
  localparam int ROWS_WIDE = 8;
  localparam logic [CFG_W-1:0] CFG_A_MASK = 8'hF3;
  localparam logic [CFG_W-1:0] CFG_B_MASK = 8'hF7;

  // Synchronized serial events, valid for one system clock
  typedef struct packed {
    logic ce_rise;
    logic ce_fall;
    logic ce_lvl;
    logic sck_rise;
    logic din;
  } ser_evt_t;
endpackage

// File: rtl/ser_in_sync.sv
module ser_in_sync
  import ser_cmd_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     sel,
  input  logic     sclk,
  input  logic     sdi,
  output ser_evt_t evt
);
  localparam int LAST = STAGES - 1;

  // bit 2 = select, bit 1 = serial clock, bit 0 = data
  logic [STAGES-1:0][2:0] stg;
  logic [1:0] prv;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
      prv <= '0;
    end else begin
      stg[0] <= {sel, sclk, sdi};
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prv <= stg[LAST][2:1];
    end
  end

  always_comb begin
    evt.ce_lvl   = stg[LAST][2];
    evt.ce_rise  = stg[LAST][2] & ~prv[1];
    evt.ce_fall  = ~stg[LAST][2] & prv[1];
    evt.sck_rise = stg[LAST][1] & ~prv[0];
    evt.din      = stg[LAST][0];
  end
endmodule

// File: rtl/ser_frame_rx.sv
module ser_frame_rx
  import ser_cmd_pkg::*;
#(
  parameter int FRAME_BITS = 40,
  parameter int CNT_W = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ser_evt_t              evt,
  input  logic                  reading,
  output logic [CNT_W-1:0]      cnt,
  output logic [FRAME_BITS-1:0] shreg,
  output logic                  frame_end
);
  logic take;

  assign take = evt.sck_rise & evt.ce_lvl & ~reading & (cnt < CNT_W'(FRAME_BITS));
  assign frame_end = evt.ce_fall & ~reading;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      shreg <= '0;
    end else if (evt.ce_rise) begin
      cnt   <= '0;
      shreg <= '0;
    end else if (take) begin
      shreg[cnt] <= evt.din;
      cnt        <= cnt + CNT_W'(1);
    end
  end

  AST_FRAME_CAP: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(FRAME_BITS)); // R3
  AST_HOLD_IN_READ: assert property (@(posedge clk) disable iff (rst)
    reading |=> $stable(cnt)); // R8
endmodule

// File: rtl/ser_cmd_decode.sv
module ser_cmd_decode
  import ser_cmd_pkg::*;
#(
  parameter int FRAME_BITS = 40,
  parameter int CNT_W = 6,
  parameter int DATA_BITS = 36,
  parameter int LEN_W = 6,
  parameter int ROW_W = 3,
  parameter int KEY_GROUPS = 2,
  parameter int GRP_W = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_end,
  input  logic [CNT_W-1:0]      cnt,
  input  logic [FRAME_BITS-1:0] shreg,
  output logic                  disp_we,
  output logic [ROW_W-1:0]      disp_row,
  output logic [DATA_BITS-1:0]  disp_data,
  output logic [LEN_W-1:0]      disp_len,
  output logic [CFG_W-1:0]      cfg_a,
  output logic [CFG_W-1:0]      cfg_b,
  output logic                  arm_req,
  output logic [GRP_W-1:0]      arm_grp
);
  logic [ADDR_W-1:0]    addr;
  logic [DATA_BITS-1:0] payload;
  logic                 commit, row_ok, key_ok;

  assign addr    = shreg[ADDR_W-1:0];
  assign payload = shreg[FRAME_BITS-1:ADDR_W];
  assign commit  = frame_end & (cnt >= CNT_W'(ADDR_W));
  assign row_ok  = int'(addr) < (cfg_a[0] ? ROWS_WIDE : ROWS_NARROW);
  assign key_ok  = (int'(addr) >= int'(ADR_KEY_LO)) &&
                   (int'(addr) < int'(ADR_KEY_LO) + KEY_GROUPS);
  assign arm_req = commit & key_ok;
  assign arm_grp = GRP_W'(addr - ADR_KEY_LO);

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_we   <= 1'b0;
      disp_row  <= '0;
      disp_data <= '0;
      disp_len  <= '0;
      cfg_a     <= '0;
      cfg_b     <= '0;
    end else begin
      disp_we <= 1'b0;
      if (commit) begin
        if (row_ok) begin
          disp_we   <= 1'b1;
          disp_row  <= addr[ROW_W-1:0];
          disp_data <= payload;
          disp_len  <= LEN_W'(cnt - CNT_W'(ADDR_W));
        end
        if (addr == ADR_CFG_A) cfg_a <= payload[CFG_W-1:0] & CFG_A_MASK;
        if (addr == ADR_CFG_B) cfg_b <= payload[CFG_W-1:0] & CFG_B_MASK;
      end
    end
  end

  AST_ROW_LEGAL: assert property (@(posedge clk) disable iff (rst)
    disp_we |-> (int'(disp_row) < ROWS_NARROW || cfg_a[0])); // R4
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    disp_we |=> !disp_we); // R11
  AST_LEN_CAP: assert property (@(posedge clk) disable iff (rst)
    disp_we |-> int'(disp_len) <= DATA_BITS); // R3
endmodule

// File: rtl/ser_key_tx.sv
module ser_key_tx #(
  parameter int KEY_BITS = 56,
  parameter int KEY_GROUPS = 2,
  parameter int GRP_W = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ce_rise,
  input  logic                ce_fall,
  input  logic                ce_lvl,
  input  logic                sck_rise,
  input  logic                arm_req,
  input  logic [GRP_W-1:0]    arm_grp,
  input  logic                key_flag,
  input  logic [KEY_BITS-1:0] key_bits,
  output logic                reading,
  output logic                sdo_low
);
  localparam int GRP_KEYS = KEY_BITS / KEY_GROUPS;
  localparam int SH_W = GRP_KEYS + 1;

  logic [GRP_KEYS-1:0] grp_keys [KEY_GROUPS];
  logic [GRP_KEYS-1:0] sel_keys;
  logic [SH_W-1:0]     sh;
  logic [GRP_W-1:0]    grp;
  logic                armed;

  for (genvar g = 0; g < KEY_GROUPS; g++) begin : g_grp
    assign grp_keys[g] = key_bits[g*GRP_KEYS +: GRP_KEYS];
  end
  assign sel_keys = grp_keys[grp];

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      grp     <= '0;
      reading <= 1'b0;
      sh      <= '0;
      sdo_low <= 1'b0;
    end else begin
      if (arm_req) begin
        armed <= 1'b1;
        grp   <= arm_grp;
      end
      if (ce_rise && armed) begin
        armed   <= 1'b0;
        reading <= 1'b1;
        sh      <= {sel_keys, key_flag};
        sdo_low <= ~key_flag;
      end else if (reading && ce_fall) begin
        reading <= 1'b0;
        sdo_low <= 1'b0;
      end else if (reading && sck_rise && ce_lvl) begin
        sh      <= {1'b1, sh[SH_W-1:1]};
        sdo_low <= ~sh[1];
      end
    end
  end

  AST_READ_FROM_ARM: assert property (@(posedge clk) disable iff (rst)
    $rose(reading) |-> $past(armed)); // R8
  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !reading |-> !sdo_low); // R10
  AST_SEL_LOW_ENDS: assert property (@(posedge clk) disable iff (rst)
    (reading && !ce_lvl) |=> !reading); // R9
endmodule

// File: rtl/ser_cmd_port.sv
module ser_cmd_port
  import ser_cmd_pkg::*;
#(
  parameter int FRAME_BITS = 40,
  parameter int KEY_BITS = 56,
  parameter int KEY_GROUPS = 2,
  parameter int SYNC_STAGES = 2,
  parameter int ROW_W = 3,
  localparam int DATA_BITS = FRAME_BITS - ADDR_W,
  localparam int CNT_W = $clog2(FRAME_BITS + 1),
  localparam int LEN_W = $clog2(DATA_BITS + 1),
  localparam int GRP_W = (KEY_GROUPS > 1) ? $clog2(KEY_GROUPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sel,
  input  logic                 sclk,
  input  logic                 sdi,
  input  logic                 key_flag,
  input  logic [KEY_BITS-1:0]  key_bits,
  output logic                 sdo_low,
  output logic                 disp_we,
  output logic [ROW_W-1:0]     disp_row,
  output logic [DATA_BITS-1:0] disp_data,
  output logic [LEN_W-1:0]     disp_len,
  output logic                 duty8,
  output logic                 ext_clk,
  output logic [3:0]           gp_mode,
  output logic                 all_on,
  output logic                 all_off,
  output logic                 run,
  output logic [3:0]           gp_val
);
  ser_evt_t              evt;
  logic                  reading, frame_end, arm_req;
  logic [CNT_W-1:0]      cnt;
  logic [FRAME_BITS-1:0] shreg;
  logic [GRP_W-1:0]      arm_grp;
  logic [CFG_W-1:0]      cfg_a, cfg_b;

  ser_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sel(sel), .sclk(sclk), .sdi(sdi), .evt(evt)
  );

  ser_frame_rx #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .evt(evt), .reading(reading),
    .cnt(cnt), .shreg(shreg), .frame_end(frame_end)
  );

  ser_cmd_decode #(
    .FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W), .DATA_BITS(DATA_BITS),
    .LEN_W(LEN_W), .ROW_W(ROW_W), .KEY_GROUPS(KEY_GROUPS), .GRP_W(GRP_W)
  ) u_dec (
    .clk(clk), .rst(rst), .frame_end(frame_end), .cnt(cnt), .shreg(shreg),
    .disp_we(disp_we), .disp_row(disp_row), .disp_data(disp_data),
    .disp_len(disp_len), .cfg_a(cfg_a), .cfg_b(cfg_b),
    .arm_req(arm_req), .arm_grp(arm_grp)
  );

  ser_key_tx #(.KEY_BITS(KEY_BITS), .KEY_GROUPS(KEY_GROUPS), .GRP_W(GRP_W)) u_key (
    .clk(clk), .rst(rst), .ce_rise(evt.ce_rise), .ce_fall(evt.ce_fall),
    .ce_lvl(evt.ce_lvl), .sck_rise(evt.sck_rise), .arm_req(arm_req),
    .arm_grp(arm_grp), .key_flag(key_flag), .key_bits(key_bits),
    .reading(reading), .sdo_low(sdo_low)
  );

  assign duty8   = cfg_a[0];
  assign ext_clk = cfg_a[1];
  assign gp_mode = cfg_a[7:4];
  assign all_on  = cfg_b[0];
  assign all_off = cfg_b[1];
  assign run     = cfg_b[2];
  assign gp_val  = cfg_b[7:4];

  AST_NO_COMMIT_IN_READ: assert property (@(posedge clk) disable iff (rst)
    reading |=> !disp_we); // R9
endmodule

// File: tb/tb_ser_cmd_port.sv
`timescale 1ns/1ps
module tb_ser_cmd_port;
  localparam int KB = 56;

  logic clk = 1'b0, rst = 1'b1, sel = 1'b0, sclk = 1'b0, sdi = 1'b0, key_flag = 1'b0;
  logic [KB-1:0] key_bits = '0;
  logic sdo_low, disp_we, duty8, ext_clk, all_on, all_off, run;
  logic [2:0] disp_row;
  logic [35:0] disp_data;
  logic [5:0] disp_len;
  logic [3:0] gp_mode, gp_val;

  ser_cmd_port dut (
    .clk(clk), .rst(rst), .sel(sel), .sclk(sclk), .sdi(sdi),
    .key_flag(key_flag), .key_bits(key_bits), .sdo_low(sdo_low),
    .disp_we(disp_we), .disp_row(disp_row), .disp_data(disp_data),
    .disp_len(disp_len), .duty8(duty8), .ext_clk(ext_clk), .gp_mode(gp_mode),
    .all_on(all_on), .all_off(all_off), .run(run), .gp_val(gp_val)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit cmp_on = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [3:0] h_ce = '0, h_sk = '0, h_di = '0;
  bit m_reading = 0, m_armed = 0, m_sdo = 0, m_we = 0;
  int m_grp = 0, m_cnt = 0, m_row = 0, m_len = 0;
  logic [39:0] m_frame = '0;
  logic [35:0] m_data = '0;
  logic [7:0] m_ca = '0, m_cb = '0;
  bit rd_q[$];

  always @(posedge clk) begin
    if (rst) begin
      h_ce = '0; h_sk = '0; h_di = '0;
      m_reading = 0; m_armed = 0; m_sdo = 0; m_we = 0; m_grp = 0; m_cnt = 0;
      m_row = 0; m_len = 0; m_frame = '0; m_data = '0; m_ca = '0; m_cb = '0;
      rd_q.delete();
    end else begin
      bit rise, fall, skr, r0, a0;
      int c0, adr;
      h_ce = {h_ce[2:0], sel};
      h_sk = {h_sk[2:0], sclk};
      h_di = {h_di[2:0], sdi};
      rise = h_ce[2] && !h_ce[3];
      fall = !h_ce[2] && h_ce[3];
      skr  = h_sk[2] && !h_sk[3];
      r0 = m_reading; a0 = m_armed; c0 = m_cnt;
      m_we = 0;
      if (rise) begin
        m_cnt = 0; m_frame = '0;
      end else if (skr && h_ce[2] && !r0 && m_cnt < 40) begin
        m_frame[m_cnt] = h_di[2];
        m_cnt++;
      end
      if (fall && !r0 && c0 >= 4) begin
        adr = int'(m_frame[3:0]);
        if (adr < 5 || (adr < 8 && m_ca[0])) begin
          m_we = 1; m_row = adr; m_data = m_frame[39:4]; m_len = c0 - 4;
        end
        if (adr == 8) m_ca = m_frame[11:4] & 8'hF3;
        if (adr == 9) m_cb = m_frame[11:4] & 8'hF7;
        if (adr == 10 || adr == 11) begin m_armed = 1; m_grp = adr - 10; end
      end
      if (rise && a0) begin
        m_armed = 0; m_reading = 1;
        rd_q.delete();
        rd_q.push_back(key_flag);
        for (int i = 0; i < 28; i++) rd_q.push_back(key_bits[m_grp*28 + i]);
        m_sdo = !rd_q[0];
      end else if (r0 && fall) begin
        m_reading = 0; m_sdo = 0; rd_q.delete();
      end else if (r0 && skr && h_ce[2]) begin
        if (rd_q.size() > 0) void'(rd_q.pop_front());
        m_sdo = (rd_q.size() > 0) ? !rd_q[0] : 1'b0;
      end
    end
  end

  // every-clock comparison, sampled away from the active edge
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk("R8/R10 sdo_low", sdo_low, m_sdo);
      chk("R11 disp_we", disp_we, m_we);
      if (m_we) begin
        chk("R2 disp_row", disp_row, m_row);
        chk("R2 disp_data", disp_data, m_data);
        chk("R5 disp_len", disp_len, m_len);
      end
      chk("R6 cfg8", {gp_mode, 2'b00, ext_clk, duty8}, m_ca);
      chk("R6 cfg9", {gp_val, 1'b0, run, all_off, all_on}, m_cb);
    end
  end

  // write monitor for scenario checks
  int we_cnt = 0, l_row = 0, l_len = 0;
  logic [35:0] l_data = '0;
  always @(negedge clk) if (!rst && disp_we) begin
    we_cnt++; l_row = int'(disp_row); l_data = disp_data; l_len = int'(disp_len);
  end

  // ---------------- stimulus ----------------
  task automatic send(logic [63:0] v, int n, bit cut_last = 0);
    @(negedge clk); sel = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdi = v[i];
      repeat (2) @(negedge clk);
      if (cut_last && i == n - 1) begin
        sclk = 1'b1; sel = 1'b0;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
        repeat (8) @(negedge clk);
        return;
      end
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    sel = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  bit got[$];
  task automatic readout(int n);
    got.delete();
    @(negedge clk); sel = 1'b1;
    repeat (5) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      got.push_back(!sdo_low);
      sdi = ~sdi;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
    sel = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  function automatic bit exp_bit(int g, int i);
    if (i == 0) return key_flag;
    if (i <= 28) return key_bits[g*28 + i - 1];
    return 1'b1;
  endfunction

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n0;
    key_bits = 56'h9C_5A_0F_E1_36_A7_4B;
    key_flag = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7 reset state
    chk("R7 reset outputs", {sdo_low, disp_we, duty8, ext_clk, gp_mode, all_on, all_off, run, gp_val}, 0);
    chk("R7 reset disp", {disp_row, disp_len, disp_data}, 0);
    cmp_on = 1;

    // R2 full row 0 frame
    send({24'h0, 36'h9_8765_4321, 4'h0}, 40);
    chk("R2 row0 count", we_cnt, 1);
    chk("R2 row0 data", l_data, 36'h9_8765_4321);
    chk("R2 row0 row", l_row, 0);

    // R4 row 5 rejected in narrow mode
    send({48'h0, 12'hABC, 4'h5}, 40);
    chk("R4 row5 narrow rejected", we_cnt, 1);

    // R5 short frame
    send({52'h0, 8'hA5, 4'h2}, 12);
    chk("R5 short row", l_row, 2);
    chk("R5 short data", l_data, 36'hA5);
    chk("R5 short len", l_len, 8);

    // R11 under four bits
    n0 = we_cnt;
    send(64'h0, 3);
    chk("R11 three bits no commit", we_cnt, n0);

    // R6 config A, reserved bits discarded
    send({52'h0, 8'hAF, 4'h8}, 12);
    chk("R6 duty8", duty8, 1);
    chk("R6 ext_clk", ext_clk, 1);
    chk("R6 gp_mode", gp_mode, 4'hA);

    // R4 row 7 accepted in wide mode
    send({24'h0, 36'h1_2345_6789, 4'h7}, 40);
    chk("R4 row7 wide row", l_row, 7);
    chk("R4 row7 wide data", l_data, 36'h1_2345_6789);

    // R3 overlong frame
    send({19'h0, 5'h1F, 36'hF_0F0F_0F0F, 4'h3}, 45);
    chk("R3 overlong len", l_len, 36);
    chk("R3 overlong data", l_data, 36'hF_0F0F_0F0F);

    // R6 config B, then R5 short config clears missing bits
    send({52'h0, 8'hFF, 4'h9}, 12);
    chk("R6 cfg9 full", {gp_val, run, all_off, all_on}, 7'h7F);
    send({57'h0, 3'b100, 4'h9}, 7);
    chk("R5 cfg9 short", {gp_val, run, all_off, all_on}, 7'b0000_100);

    // R4 address 13 ignored
    n0 = we_cnt;
    send({52'h0, 8'hFF, 4'hD}, 12);
    chk("R4 addr13 no write", we_cnt, n0);
    chk("R4 addr13 cfg unchanged", {duty8, ext_clk, gp_mode, gp_val, run, all_off, all_on}, {2'b11, 4'hA, 7'b0000_100});

    // R1 clocks while select low
    n0 = we_cnt;
    for (int i = 0; i < 10; i++) begin
      sdi = i[0];
      repeat (2) @(negedge clk); sclk = 1'b1;
      repeat (3) @(negedge clk); sclk = 1'b0;
    end
    repeat (6) @(negedge clk);
    chk("R1 idle clocks no write", we_cnt, n0);
    send({56'h0, 4'h5, 4'h1}, 8);
    chk("R1 next frame len", l_len, 4);
    chk("R1 next frame data", l_data, 36'h5);

    // R8 full readout of group 0
    n0 = we_cnt;
    send({60'h0, 4'hA}, 4);
    readout(31);
    for (int i = 0; i < 31; i++) chk("R8 group0 bit", got[i], exp_bit(0, i));
    chk("R9 released after readout", sdo_low, 0);
    chk("R9 no commit from readout", we_cnt, n0);

    // R9 early stop on group 1, then normal frame
    send({60'h0, 4'hB}, 4);
    readout(10);
    for (int i = 0; i < 10; i++) chk("R8 group1 bit", got[i], exp_bit(1, i));
    chk("R9 early stop released", sdo_low, 0);
    send({56'h0, 4'h6, 4'h3}, 8);
    chk("R9 frame after readout row", l_row, 3);
    chk("R9 frame after readout data", l_data, 36'h6);

    // R12 last clock edge coincident with select fall
    send({52'h0, 8'hBC, 4'h4}, 12, 1);
    chk("R12 coincident row", l_row, 4);
    chk("R12 coincident len", l_len, 7);
    chk("R12 coincident data", l_data, 36'h3C);

    repeat (10) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule